// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the control-port end of a converter-style device. A host reaches a small internal register file over three wires: a serial clock, an active-low select, and one data line that both sides share. The host first sends a 16-bit instruction. The instruction holds a direction flag, a code for the transfer length and a 13-bit start address. Data bytes follow, each to or from the next address in turn.

While the select is high the framing logic is held in reset. Every frame therefore starts again from the first instruction bit. The block drives the shared line only while it returns read data. The host model and the block each have their own output enable on that line. Storage exists only at the lowest `REG_DEPTH` addresses. The rest of the 13-bit space behaves as empty.

Top module: `spi3w_regslave`

## Requirements
- R1: After `rst_n` is released, every register reads 0x00 and `sdio_oe` is low.
- R2: The instruction is 16 bits, sent MSB first and sampled on the rising SCLK edge. Bit 15 selects the direction (1 = read, 0 = write). Bits 14:13 are the length code. Bits 12:0 are the start address.
- R3: Length codes 00, 01 and 10 allow 1, 2 and 3 data bytes. Any byte clocked after that is ignored: it writes nothing and is not driven.
- R4: Length code 11 keeps the transfer going byte after byte until `cs_n` rises.
- R5: Each data byte goes to the address after the previous one. The address wraps from 0x1FFF to 0x0000.
- R6: A write changes a register only once all 8 bits of the data byte are sampled. A byte cut short by `cs_n` rising leaves the register as it was.
- R7: Read data is fetched from the current address at the start of each byte. It is driven MSB first, changing on the falling SCLK edge. `sdio_oe` is high only during read data bytes that fall within the length.
- R8: `sdio_oe` falls at the same moment `cs_n` rises, even in the middle of a byte.
- R9: Addresses at or above `REG_DEPTH` read 0x00, and writes to them have no effect.
- R10: Raising `cs_n` part-way through an instruction discards it, and the next frame decodes from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| cs_n | input | 1 | Active-low frame select; high resets the framing logic |
| sdio_in | input | 1 | Value seen on the shared data line |
| sdio_out | output | 1 | Value this block drives onto the shared data line |
| sdio_oe | output | 1 | Output enable of this block's driver on the shared line |

## Verification
A write takes effect at the rising edge that samples its eighth data bit. The address advances at that same edge. Each read bit appears just after the falling edge that comes before the rising edge where the host samples it. The output enable falls with no clock at all when the select rises. The bench therefore compares the enable and the line value 3 ns after every falling edge, against a behavioural model that knows only the bit position within the frame. It checks the enable again 1 ns after each select rise, and checks write effects through later reads rather than at the edge itself.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int ADDR_W  = 13;
  localparam int INSTR_W = 16;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_e;

  typedef struct packed {
    logic              rd;
    logic [1:0]        len;
    logic [ADDR_W-1:0] addr;
  } instr_t;

  // next register address, wrapping over the full 13-bit space
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  // true when byte number idx (0-based) is the final one allowed by code len
  function automatic logic is_last_byte(input logic [1:0] len, input logic [1:0] idx);
    return (len != 2'b11) && (idx == len);
  endfunction
endpackage

// File: rtl/spi3w_frame.sv
module spi3w_frame
  import spi3w_pkg::*;
(
  input  logic              sclk,
  input  logic              frame_rst,
  input  logic              sdio_in,
  output phase_e            phase,
  output logic              is_read,
  output logic [1:0]        len_code,
  output logic [2:0]        bit_idx,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              byte_done,
  output logic              wr_en,
  output logic [7:0]        wr_data
);
  logic [3:0]         icnt;
  logic [INSTR_W-2:0] ish;
  logic [6:0]         dsh;
  logic [1:0]         bcnt;
  instr_t             instr_w;

  assign instr_w   = instr_t'({ish, sdio_in});
  assign byte_done = (phase == PH_DATA) && (bit_idx == 3'd7);
  assign wr_en     = byte_done && !is_read;
  assign wr_data   = {dsh, sdio_in};

  always_ff @(posedge sclk or posedge frame_rst) begin
    if (frame_rst) begin
      phase    <= PH_INSTR;
      icnt     <= '0;
      ish      <= '0;
      dsh      <= '0;
      bcnt     <= '0;
      bit_idx  <= '0;
      is_read  <= 1'b0;
      len_code <= '0;
      cur_addr <= '0;
    end else begin
      case (phase)
        PH_INSTR: begin
          ish  <= {ish[INSTR_W-3:0], sdio_in};
          icnt <= icnt + 4'd1;
          if (icnt == 4'd15) begin
            is_read  <= instr_w.rd;
            len_code <= instr_w.len;
            cur_addr <= instr_w.addr;
            phase    <= PH_DATA;
            bit_idx  <= '0;
            bcnt     <= '0;
          end
        end
        PH_DATA: begin
          dsh     <= {dsh[5:0], sdio_in};
          bit_idx <= bit_idx + 3'd1;
          if (byte_done) begin
            cur_addr <= addr_next(cur_addr);
            if (is_last_byte(len_code, bcnt)) phase <= PH_DONE;
            else if (bcnt != 2'd3) bcnt <= bcnt + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi3w_regfile.sv
module spi3w_regfile
  import spi3w_pkg::*;
#(
  parameter int REG_DEPTH = 32
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  localparam int IDX_W = (REG_DEPTH > 1) ? $clog2(REG_DEPTH) : 1;

  logic [7:0]       regs [REG_DEPTH];
  logic             in_range;
  logic [IDX_W-1:0] idx;

  assign in_range = ({{(32-ADDR_W){1'b0}}, addr} < 32'(REG_DEPTH));
  assign idx      = addr[IDX_W-1:0];
  assign rd_data  = in_range ? regs[idx] : 8'h00;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_DEPTH; i++) regs[i] <= 8'h00;
    end else if (wr_en && in_range) begin
      regs[idx] <= wr_data;
    end
  end
endmodule

// File: rtl/spi3w_txshift.sv
module spi3w_txshift (
  input  logic       sclk,
  input  logic       frame_rst,
  input  logic       rd_active,
  input  logic [2:0] bit_idx,
  input  logic [7:0] rd_data,
  output logic       sdio_out,
  output logic       oe_q
);
  logic [7:0] sh;

  assign sdio_out = sh[7];

  // launches on the falling edge so data is settled before the host samples it
  always_ff @(negedge sclk or posedge frame_rst) begin
    if (frame_rst) begin
      sh   <= 8'h00;
      oe_q <= 1'b0;
    end else if (rd_active) begin
      oe_q <= 1'b1;
      sh   <= (bit_idx == 3'd0) ? rd_data : {sh[6:0], 1'b0};
    end else begin
      oe_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi3w_regslave.sv
module spi3w_regslave
  import spi3w_pkg::*;
#(
  parameter int REG_DEPTH = 32
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe
);
  logic              frame_rst;
  phase_e            phase;
  logic              is_read;
  logic [1:0]        len_code;
  logic [2:0]        bit_idx;
  logic [ADDR_W-1:0] cur_addr;
  logic              byte_done_w;
  logic              wr_en;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;
  logic              oe_q;
  logic              data_phase_w;
  logic              done_phase_w;
  logic              rd_active;

  assign frame_rst    = cs_n | ~rst_n;
  assign data_phase_w = (phase == PH_DATA);
  assign done_phase_w = (phase == PH_DONE);
  assign rd_active    = data_phase_w && is_read;
  assign sdio_oe      = oe_q & ~cs_n;

  spi3w_frame u_frame (
    .sclk      (sclk),
    .frame_rst (frame_rst),
    .sdio_in   (sdio_in),
    .phase     (phase),
    .is_read   (is_read),
    .len_code  (len_code),
    .bit_idx   (bit_idx),
    .cur_addr  (cur_addr),
    .byte_done (byte_done_w),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  spi3w_regfile #(.REG_DEPTH(REG_DEPTH)) u_regs (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (cur_addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  spi3w_txshift u_tx (
    .sclk      (sclk),
    .frame_rst (frame_rst),
    .rd_active (rd_active),
    .bit_idx   (bit_idx),
    .rd_data   (rd_data),
    .sdio_out  (sdio_out),
    .oe_q      (oe_q)
  );
endmodule

// File: rtl/spi3w_regslave_chk.sv
module spi3w_regslave_chk (
  input logic        sclk,
  input logic        frame_rst,
  input logic        sdio_oe,
  input logic        data_phase,
  input logic        done_phase,
  input logic        is_read,
  input logic [1:0]  len_code,
  input logic [2:0]  bit_idx,
  input logic [12:0] cur_addr,
  input logic        byte_done
);
  // R7
  oe_read_data_chk: assert property (@(posedge sclk) disable iff (frame_rst)
    sdio_oe |-> (data_phase && is_read));

  // R7
  oe_byte_start_chk: assert property (@(posedge sclk) disable iff (frame_rst)
    $rose(sdio_oe) |-> (bit_idx == 3'd0));

  // R5
  addr_step_chk: assert property (@(posedge sclk) disable iff (frame_rst)
    byte_done |=> (cur_addr == $past(cur_addr) + 13'd1));

  // R5
  addr_hold_chk: assert property (@(posedge sclk) disable iff (frame_rst)
    (data_phase && !byte_done) |=> $stable(cur_addr));

  // R3
  done_sticky_chk: assert property (@(posedge sclk) disable iff (frame_rst)
    done_phase |=> done_phase);

  // R4
  burst_open_chk: assert property (@(posedge sclk) disable iff (frame_rst)
    (data_phase && len_code == 2'b11) |=> !done_phase);
endmodule

bind spi3w_regslave spi3w_regslave_chk u_chk (
  .sclk       (sclk),
  .frame_rst  (frame_rst),
  .sdio_oe    (sdio_oe),
  .data_phase (data_phase_w),
  .done_phase (done_phase_w),
  .is_read    (is_read),
  .len_code   (len_code),
  .bit_idx    (bit_idx),
  .cur_addr   (cur_addr),
  .byte_done  (byte_done_w)
);

// File: tb/sim_spi3w_regslave.sv
module sim_spi3w_regslave;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic host_oe = 1'b0;
  logic host_d = 1'b0;
  logic sdio_out, sdio_oe, pin;
  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [int];
  logic [7:0] txq [$];

  always #5 clk = ~clk;

  // shared line: whichever side has its driver enabled sets it; a pull-up holds it otherwise
  always_comb begin
    if (sdio_oe)      pin = sdio_out;
    else if (host_oe) pin = host_d;
    else              pin = 1'b1;
  end

  spi3w_regslave #(.REG_DEPTH(DEPTH)) u0 (
    .sclk     (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdio_in  (pin),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mread(input int a);
    if (a < DEPTH && mdl.exists(a)) return mdl[a];
    return 8'h00;
  endfunction

  // one framed transfer of nbits clocks; the model predicts enable and line value per bit
  task automatic xfer(input string req, input bit rd, input logic [1:0] lc,
                      input logic [12:0] a, input int nbits);
    logic [15:0] ins;
    ins = {rd, lc, a};
    @(posedge clk);
    #2 cs_n = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      int j;
      int b;
      bit in_len;
      bit exp_oe;
      logic [12:0] ba;
      logic [7:0] wb;
      logic [7:0] eb;
      j = (k >= 16) ? (k - 16) / 8 : 0;
      b = (k >= 16) ? (k - 16) % 8 : 0;
      @(negedge clk);
      in_len = (k >= 16) && (lc == 2'b11 || j <= int'(lc));
      ba = a + 13'(j);
      wb = (j < txq.size()) ? txq[j] : 8'hC3;
      if (k < 16) begin
        host_oe = 1'b1; host_d = ins[15-k];
      end else if (!rd) begin
        host_oe = 1'b1; host_d = wb[7-b];
      end else begin
        host_oe = 1'b0;
      end
      exp_oe = rd && in_len;
      #3;
      check(sdio_oe == exp_oe, req, int'(sdio_oe), int'(exp_oe));
      check(!(sdio_oe && host_oe), "R7 contention", int'(sdio_oe), 0);
      if (exp_oe) begin
        eb = mread(int'(ba));
        check(pin == eb[7-b], req, int'(pin), int'(eb[7-b]));
      end
      @(posedge clk);
      if (!rd && in_len && b == 7) mdl[int'(ba)] = wb;
    end
    #2 cs_n = 1'b1;
    host_oe = 1'b0;
    #1 check(sdio_oe == 1'b0, "R8", int'(sdio_oe), 0);
  endtask

  initial begin
    #23 rst_n = 1'b1;
    #1 check(sdio_oe == 1'b0, "R1", int'(sdio_oe), 0);
    // R1: burst of 8 reads after reset, all zero
    xfer("R1", 1'b1, 2'b11, 13'd0, 16 + 64);
    // R2: single write then single read
    txq = '{8'h5A};
    xfer("R2", 1'b0, 2'b00, 13'd3, 24);
    xfer("R2", 1'b1, 2'b00, 13'd3, 24);
    // R3: code 01 write sends a third byte that must be dropped
    txq = '{8'h11, 8'h22, 8'h33};
    xfer("R3", 1'b0, 2'b01, 13'd10, 40);
    xfer("R3", 1'b1, 2'b11, 13'd10, 40);
    xfer("R3", 1'b1, 2'b01, 13'd10, 40);
    txq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    xfer("R3", 1'b0, 2'b10, 13'd13, 48);
    xfer("R3", 1'b1, 2'b10, 13'd12, 48);
    // R4: open-ended burst
    txq = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB};
    xfer("R4", 1'b0, 2'b11, 13'd20, 16 + 48);
    xfer("R7", 1'b1, 2'b11, 13'd19, 16 + 64);
    // R5: wrap from the top address to zero
    txq = '{8'h77, 8'h88};
    xfer("R5", 1'b0, 2'b11, 13'h1FFF, 32);
    xfer("R5", 1'b1, 2'b01, 13'h1FFF, 32);
    // R6: byte cut short leaves register 5 unchanged
    txq = '{8'hEE};
    xfer("R6", 1'b0, 2'b00, 13'd5, 21);
    xfer("R6", 1'b1, 2'b00, 13'd5, 24);
    // R9: unimplemented address
    txq = '{8'h99};
    xfer("R9", 1'b0, 2'b00, 13'd100, 24);
    xfer("R9", 1'b1, 2'b00, 13'd100, 24);
    // R10: aborted instruction, then a clean read
    xfer("R10", 1'b1, 2'b00, 13'd3, 7);
    xfer("R10", 1'b1, 2'b00, 13'd3, 24);
    // R8: select rises mid byte of a read
    xfer("R8", 1'b1, 2'b11, 13'd20, 16 + 12);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule